// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns one decimal digit, presented as a stream of four bits with the least significant bit first, into its Excess-3 form, which is the digit plus three. A bit is accepted on each clock cycle in which the bit-valid strobe is high. For that bit the block answers in the same cycle with the matching output bit, so the answer depends on the current state and the current input. After four accepted bits the block is back in its start state, ready for the next digit. Cycles in which the strobe is low do not count.

Inside, a 16-entry table is indexed by the input bit and the 3-bit state code. Each entry gives the output bit, the next state and an error mark. A seven-state machine walks through this table. An input of one in the last state of the deepest path means the code was not a valid decimal digit. That bit raises a one-cycle error flag, and the machine returns to its start state.

Top module: `bcd_xs3_serial`

## Requirements
- R1: A synchronous active-high reset, including one that arrives in the middle of a digit, puts the machine in its start state (code 000) and clears `err_o`. The next accepted bit is then treated as the least significant bit of a new digit.
- R2: For each digit 0 to 9, sent LSB first on `x_i` with `valid_i` high, the four `z_o` values seen on those four cycles form the digit plus three, also LSB first.
- R3: The state codes are 000, 001, 011, 110, 100, 111 and 101 for states 0 to 6. Code 010 is never entered. The transitions are:
  - State 0 goes to state 1 or 2 on input 0 or 1. State 1 goes to state 3 or 4.
  - State 2 goes to state 4 and state 3 goes to state 5 on either input.
  - State 4 goes to state 5 or 6. States 5 and 6 go to state 0.
- R4: A cycle with `valid_i` low leaves the state unchanged, whatever `x_i` holds, and raises no error.
- R5: `z_o` is 0 on every cycle in which `valid_i` is low.
- R6: Every four accepted bits return the machine to its start state, so digits sent back to back with no idle cycle between them each convert correctly.
- R7: A 1 accepted in state 6 marks an invalid code. Codes 13, 14 and 15 reach this case on their fourth bit. On that bit `z_o` is 0 and the machine returns to state 0. `err_o` is 1 for exactly the one cycle after that bit.
- R8: Codes 10, 11 and 12 are not flagged. For them, and for codes 13 to 15, the four `z_o` bits equal the low four bits of the code plus three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| x_i | input | 1 | Serial digit bit, least significant bit first |
| valid_i | input | 1 | High when `x_i` carries a bit to consume this cycle |
| z_o | output | 1 | Excess-3 bit for the current input bit (combinational) |
| err_o | output | 1 | One-cycle pulse after an invalid code is detected |

## Verification
A wrong state code or a wrong table entry shows up at `z_o` in the same cycle that it is used. It can also leave the machine off the four-bit boundary, which then corrupts every later digit. Sweeping all sixteen 4-bit codes therefore exposes a bad transition within one digit. Running the sweep again with idle cycles between bits, and with back-to-back digits, shows whether the state is held or lost across those gaps. The error flag is checked in the single cycle after the fourth bit and again one cycle later, so a flag that is late, missing or stuck is seen at once.

// File: rtl/xs3_pkg.sv
package xs3_pkg;

    localparam int STATE_W = 3;
    localparam int ADDR_W  = STATE_W + 1;
    localparam int ROM_N   = 2 ** ADDR_W;

    typedef enum logic [STATE_W-1:0] {
        ST_0 = 3'b000,
        ST_1 = 3'b001,
        ST_2 = 3'b011,
        ST_3 = 3'b110,
        ST_4 = 3'b100,
        ST_5 = 3'b111,
        ST_6 = 3'b101
    } state_e;

    typedef struct packed {
        logic   err;
        logic   z;
        state_e nxt;
    } rom_word_t;

    typedef struct packed {
        state_e state;
        logic   err;
    } step_regs_t;

endpackage

// File: rtl/xs3_rom.sv
module xs3_rom
    import xs3_pkg::*;
(
    input  logic      x_i,
    input  state_e    state_i,
    output rom_word_t word_o
);

    function automatic rom_word_t make_entry(input logic x, input logic [STATE_W-1:0] s);
        rom_word_t e;
        e.err = 1'b0;
        e.z   = ~x;
        e.nxt = ST_0;
        case (s)
            ST_0: e.nxt = x ? ST_2 : ST_1;
            ST_1: e.nxt = x ? ST_4 : ST_3;
            ST_2: begin e.z = x; e.nxt = ST_4; end
            ST_3: begin e.z = x; e.nxt = ST_5; end
            ST_4: e.nxt = x ? ST_6 : ST_5;
            ST_5: begin e.z = x; e.nxt = ST_0; end
            ST_6: begin
                if (x) begin
                    e.err = 1'b1;
                    e.z   = 1'b0;
                end
                e.nxt = ST_0;
            end
            default: begin
                e.err = 1'b1;
                e.z   = 1'b0;
                e.nxt = ST_0;
            end
        endcase
        return e;
    endfunction

    rom_word_t tbl [ROM_N];

    for (genvar a = 0; a < ROM_N; a++) begin : g_tbl
        localparam logic [ADDR_W-1:0] AV = ADDR_W'(a);
        assign tbl[a] = make_entry(AV[ADDR_W-1], AV[STATE_W-1:0]);
    end

    assign word_o = tbl[{x_i, state_i}];

    // R7: an error entry always sends the machine home
    always_comb begin
        a_err_home_r7: assert (!word_o.err || word_o.nxt == ST_0);
    end

endmodule

// File: rtl/xs3_step_reg.sv
module xs3_step_reg
    import xs3_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      valid_i,
    input  logic      x_i,
    input  rom_word_t word_i,
    output state_e    state_o,
    output logic      err_o
);

    step_regs_t regs_d, regs_q;

    always_comb begin
        regs_d     = regs_q;
        regs_d.err = 1'b0;
        if (valid_i) begin
            regs_d.state = word_i.nxt;
            regs_d.err   = word_i.err;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            regs_q.state <= ST_0;
            regs_q.err   <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign err_o   = regs_q.err;

    p_hold_when_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(regs_q.state));

    p_legal_code_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        regs_q.state != 3'b010);

    p_err_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        regs_q.err |=> !regs_q.err);

    p_err_lands_home_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        regs_q.err |-> regs_q.state == ST_0);

    p_err_cause_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && x_i && regs_q.state == ST_6) |=> regs_q.err);

endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial
    import xs3_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic x_i,
    input  logic valid_i,
    output logic z_o,
    output logic err_o
);

    state_e    state_q;
    rom_word_t word;

    xs3_rom u_rom (
        .x_i     (x_i),
        .state_i (state_q),
        .word_o  (word)
    );

    xs3_step_reg u_reg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (valid_i),
        .x_i     (x_i),
        .word_i  (word),
        .state_o (state_q),
        .err_o   (err_o)
    );

    assign z_o = valid_i & word.z;

    // Checker: accepted-bit counter used to watch digit boundaries
    logic [1:0] chk_bits_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) chk_bits_q <= 2'd0;
        else if (valid_i) chk_bits_q <= chk_bits_q + 2'd1;
    end

    p_digit_boundary_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (chk_bits_q == 2'd0) |-> state_q == ST_0);

    p_no_z_on_bad_bit_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && x_i && state_q == ST_6) |-> !z_o);

    p_reset_home_r1: assert property (@(posedge clk_i)
        rst_i |=> (state_q == ST_0 && !err_o));

endmodule

// File: tb/bcd_xs3_serial_tb.sv
module bcd_xs3_serial_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_i = 1'b0;
    logic valid_i = 1'b0;
    logic z_o, err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_xs3_serial u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .x_i     (x_i),
        .valid_i (valid_i),
        .z_o     (z_o),
        .err_o   (err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, output logic z);
        @(negedge clk);
        x_i = b;
        valid_i = 1'b1;
        #1 z = z_o;
    endtask

    task automatic idle(output logic e, output logic z);
        @(negedge clk);
        valid_i = 1'b0;
        x_i = ~x_i;
        #1;
        e = err_o;
        z = z_o;
    endtask

    // Sends one 4-bit code LSB first; optional idle cycle between bits
    task automatic send_code(input int d, input bit gaps, input string req, output logic [3:0] zw);
        logic [3:0] dv;
        logic zb, e, zi;
        dv = 4'(d);
        for (int i = 0; i < 4; i++) begin
            drive_bit(dv[i], zb);
            zw[i] = zb;
            if (gaps && i < 3) begin
                idle(e, zi);
                chk(zi == 1'b0, "R5 z low while idle", int'(zi), 0);
                chk(e == 1'b0, "R4 no error while idle", int'(e), 0);
            end
        end
        chk(zw == 4'(d + 3), req, int'(zw), (d + 3) % 16);
    endtask

    task automatic check_err_after(input int d);
        logic e, zi;
        string req;
        req = (d >= 13) ? "R7 err pulse" : "R8 no err";
        idle(e, zi);
        chk(e == (d >= 13), req, int'(e), int'(d >= 13));
        idle(e, zi);
        chk(e == 1'b0, "R7 err lasts one cycle", int'(e), 0);
    endtask

    initial begin
        logic [3:0] zw;
        logic e, zi;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(err_o == 1'b0, "R1 reset err", int'(err_o), 0);
        chk(z_o == 1'b0, "R1/R5 reset z", int'(z_o), 0);

        // Sweep all 16 codes (R2 digits, R8 extra codes, R7 invalid codes, R3 table)
        for (int d = 0; d < 16; d++) begin
            send_code(d, 1'b0, (d <= 9) ? "R2 R3 digit" : ((d >= 13) ? "R7 bad code z" : "R8 code z"), zw);
            check_err_after(d);
        end

        // Gapped bits: state held across idle cycles (R4, R5)
        for (int d = 0; d < 16; d++) begin
            send_code(d, 1'b1, "R4 gapped conversion", zw);
            check_err_after(d);
        end

        // Back-to-back digits without idle cycles (R6)
        for (int k = 0; k < 10; k++) begin
            send_code((k * 7) % 10, 1'b0, "R6 back-to-back", zw);
        end
        idle(e, zi);
        chk(e == 1'b0, "R6 no err after stream", int'(e), 0);

        // Reset in the middle of a digit (R1)
        drive_bit(1'b1, zi);
        drive_bit(1'b1, zi);
        @(negedge clk);
        valid_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 chk(err_o == 1'b0, "R1 mid reset err", int'(err_o), 0);
        send_code(4, 1'b0, "R1 fresh digit after reset", zw);
        send_code(13, 1'b0, "R1 R7 after reset", zw);
        idle(e, zi);
        chk(e == 1'b1, "R7 err after reset run", int'(e), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule